// File: doc/BRIEF.md
# Command Mailbox Responder

This block is the device-side end of a byte-wide command mailbox. A host places a 16-bit parameter in two outgoing bytes and then writes a command code into a third. That write starts the command. The block captures the code together with the parameter bytes as they stand at that moment. After a fixed processing delay it executes the command against its settings store. It then publishes the result in the incoming bytes: it copies the command code into an echo byte and places 16 bits of feedback in two further bytes.

The block keeps four things:
- an 8-bit digital-output latch;
- per-channel high period, low period and burst count for a set of pulse-width channels;
- a channel enable mask;
- a sampled copy of eight digital inputs, which it refreshes at a fixed interval.

A readback command returns the value last written by any setting command. Completion is visible only as the echo byte changing to the issued code. A host that wants to repeat an identical command must first issue the clear command, which sets the echo byte to zero.

Top module: `mbox_cmd_if`

## Requirements
- R1: After reset all eight mailbox bytes read 0x00 and `dout_o` is 0x00.
- R2: Register map by `addr_i`: 0 parameter low, 1 parameter high, 2 command code, 3 reserved, 4 feedback low, 5 feedback high, 6 echo, 7 sampled inputs. Bytes 0..2 read back the last value written to them. Byte 3 always reads 0x00. Writes to addresses 3..7 change no readable byte.
- R3: A write to address 2 is the trigger. The echo byte and the feedback bytes keep their old values for LATENCY-1 cycles after the trigger edge. After exactly LATENCY cycles the echo byte holds the triggering code.
- R4: Code 0x00 sets the echo byte to 0x00 and the feedback to 0x0000. The echo byte is never cleared by any other means, so an identical command repeated without 0x00 in between leaves the echo byte unchanged.
- R5: Code 0x01 loads `dout_o` from the parameter low byte and returns feedback 0x0000. Code 0x02 returns feedback {0x00, current output latch}. No other code changes `dout_o`.
- R6: The setting codes all return feedback 0x0000:
  - 0x10+2n stores the parameter as the high period of channel n.
  - 0x11+2n stores the parameter as the low period of channel n.
  - 0x14+n stores the parameter as the burst count of channel n.
  - 0x1F stores the low NUM_PWM parameter bits as the enable mask.
  - NUM_PWM is 2, so these codes are 0x10..0x15 and 0x1F.
- R7: Code 0x07 treats its parameter low byte as a setting code. It returns the value last stored by that code: the output latch for 0x01, and 0x0000 if that setting was never written since reset. A code that is not a setting code returns 0x0000.
- R8: Any other code is still echoed, returns feedback 0x0000 and changes no setting.
- R9: A trigger that arrives before the pending command has executed replaces it. The earlier command is never executed.
- R10: The inputs pass a two-stage synchronizer. Byte 7 loads the synchronized value once every SAMPLE_DIV cycles and holds it in between.
- R11: The parameter is captured on the trigger edge. Writes to bytes 0/1 after the trigger do not alter the command that is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Byte write strobe, one cycle per write |
| addr_i | input | 3 | Mailbox byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for `addr_i` |
| din_i | input | 8 | Raw digital inputs |
| dout_o | output | 8 | Digital-output latch |

## Verification
The echo byte, the feedback bytes and `dout_o` change on the edge exactly LATENCY cycles after the trigger edge. The input byte shows the value `din_i` had two edges before each sampling edge, and sampling edges fall every SAMPLE_DIV cycles after reset. A behavioural reference model advances on every rising edge. Away from the edge, it is compared against `rdata_o` for the current address and against `dout_o`. Directed checks sample one cycle before and on the completion cycle, so an early or a late result is caught.

// File: rtl/mbox_pkg.sv
`timescale 1ns/1ps
package mbox_pkg;
  localparam int BYTE_W = 8;
  localparam int PAR_W  = 16;

  localparam logic [2:0] ADR_PAR_LO = 3'd0;
  localparam logic [2:0] ADR_PAR_HI = 3'd1;
  localparam logic [2:0] ADR_CMD    = 3'd2;
  localparam logic [2:0] ADR_RSV    = 3'd3;
  localparam logic [2:0] ADR_FB_LO  = 3'd4;
  localparam logic [2:0] ADR_FB_HI  = 3'd5;
  localparam logic [2:0] ADR_ECHO   = 3'd6;
  localparam logic [2:0] ADR_DIN    = 3'd7;

  localparam logic [7:0] OP_CLEAR   = 8'h00;
  localparam logic [7:0] OP_SET_OUT = 8'h01;
  localparam logic [7:0] OP_GET_OUT = 8'h02;
  localparam logic [7:0] OP_GET_CFG = 8'h07;
  localparam logic [7:0] OP_PER_BAS = 8'h10;
  localparam logic [7:0] OP_BRST_BS = 8'h14;
  localparam logic [7:0] OP_PWM_EN  = 8'h1F;

  typedef struct packed {
    logic [BYTE_W-1:0] code;
    logic [PAR_W-1:0]  par;
  } cmd_t;
endpackage

// File: rtl/mbox_host_port.sv
`timescale 1ns/1ps
module mbox_host_port
  import mbox_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [2:0]        addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic [PAR_W-1:0]  fb_i,
  input  logic [BYTE_W-1:0] echo_i,
  input  logic [BYTE_W-1:0] samp_i,
  output logic              trig_o,
  output cmd_t              trig_cmd_o
);
  logic [BYTE_W-1:0] par_lo_q, par_hi_q, code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_lo_q <= '0;
      par_hi_q <= '0;
      code_q   <= '0;
    end else if (wr_i) begin
      case (addr_i)
        ADR_PAR_LO: par_lo_q <= wdata_i;
        ADR_PAR_HI: par_hi_q <= wdata_i;
        ADR_CMD:    code_q   <= wdata_i;
        default: ;
      endcase
    end
  end

  // parameter is taken as stored before the trigger write
  assign trig_o          = wr_i && (addr_i == ADR_CMD);
  assign trig_cmd_o.code = wdata_i;
  assign trig_cmd_o.par  = {par_hi_q, par_lo_q};

  always_comb begin
    unique case (addr_i)
      ADR_PAR_LO: rdata_o = par_lo_q;
      ADR_PAR_HI: rdata_o = par_hi_q;
      ADR_CMD:    rdata_o = code_q;
      ADR_RSV:    rdata_o = '0;
      ADR_FB_LO:  rdata_o = fb_i[BYTE_W-1:0];
      ADR_FB_HI:  rdata_o = fb_i[PAR_W-1:BYTE_W];
      ADR_ECHO:   rdata_o = echo_i;
      ADR_DIN:    rdata_o = samp_i;
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/mbox_exec.sv
`timescale 1ns/1ps
module mbox_exec
  import mbox_pkg::*;
#(
  parameter int NUM_PWM = 2,
  parameter int LATENCY = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  cmd_t              cmd_i,
  output logic [BYTE_W-1:0] echo_o,
  output logic [PAR_W-1:0]  fb_o,
  output logic [BYTE_W-1:0] dout_o
);
  localparam int CW = $clog2(LATENCY + 1);

  logic [CW-1:0]     cnt_q;
  cmd_t              pend_q;
  logic              exec;
  logic [BYTE_W-1:0] echo_q;
  logic [PAR_W-1:0]  fb_q, resp, cfg_val;
  logic [BYTE_W-1:0] dout_q;
  logic [NUM_PWM-1:0] en_q;
  logic [NUM_PWM-1:0][PAR_W-1:0] hi_v, lo_v, br_v;

  // newer trigger wins over the pending one
  assign exec = (cnt_q == CW'(1)) && !trig_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= '0;
    end else if (trig_i) begin
      cnt_q  <= CW'(LATENCY);
      pend_q <= cmd_i;
    end else if (cnt_q != '0) begin
      cnt_q  <= cnt_q - CW'(1);
    end
  end

  for (genvar ch = 0; ch < NUM_PWM; ch++) begin : g_ch
    localparam logic [7:0] C_HI = OP_PER_BAS + 8'(2 * ch);
    localparam logic [7:0] C_LO = OP_PER_BAS + 8'(2 * ch + 1);
    localparam logic [7:0] C_BR = OP_BRST_BS + 8'(ch);
    logic [PAR_W-1:0] hi_q, lo_q, br_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hi_q <= '0;
        lo_q <= '0;
        br_q <= '0;
      end else if (exec) begin
        if (pend_q.code == C_HI) hi_q <= pend_q.par;
        if (pend_q.code == C_LO) lo_q <= pend_q.par;
        if (pend_q.code == C_BR) br_q <= pend_q.par;
      end
    end

    assign hi_v[ch] = hi_q;
    assign lo_v[ch] = lo_q;
    assign br_v[ch] = br_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      dout_q <= '0;
    end else if (exec) begin
      if (pend_q.code == OP_PWM_EN)  en_q   <= pend_q.par[NUM_PWM-1:0];
      if (pend_q.code == OP_SET_OUT) dout_q <= pend_q.par[BYTE_W-1:0];
    end
  end

  // readback of the setting selected by the parameter low byte
  always_comb begin
    cfg_val = '0;
    if (pend_q.par[7:0] == OP_SET_OUT) cfg_val = {8'h00, dout_q};
    if (pend_q.par[7:0] == OP_PWM_EN)  cfg_val = PAR_W'(en_q);
    for (int ch = 0; ch < NUM_PWM; ch++) begin
      if (pend_q.par[7:0] == 8'(OP_PER_BAS + 8'(2 * ch)))     cfg_val = hi_v[ch];
      if (pend_q.par[7:0] == 8'(OP_PER_BAS + 8'(2 * ch + 1))) cfg_val = lo_v[ch];
      if (pend_q.par[7:0] == 8'(OP_BRST_BS + 8'(ch)))         cfg_val = br_v[ch];
    end
  end

  always_comb begin
    case (pend_q.code)
      OP_GET_OUT: resp = {8'h00, dout_q};
      OP_GET_CFG: resp = cfg_val;
      default:    resp = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      echo_q <= '0;
      fb_q   <= '0;
    end else if (exec) begin
      echo_q <= pend_q.code;
      fb_q   <= resp;
    end
  end

  assign echo_o = echo_q;
  assign fb_o   = fb_q;
  assign dout_o = dout_q;
endmodule

// File: rtl/mbox_din_sampler.sv
`timescale 1ns/1ps
module mbox_din_sampler #(
  parameter int W   = 8,
  parameter int DIV = 12500
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] samp_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [W-1:0]  s1_q, s2_q, samp_q;
  logic [PW-1:0] pre_q;
  logic          tick;

  assign tick = (pre_q == PW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      samp_q <= '0;
      pre_q  <= '0;
    end else begin
      s1_q  <= din_i;
      s2_q  <= s1_q;
      pre_q <= tick ? '0 : pre_q + PW'(1);
      if (tick) samp_q <= s2_q;
    end
  end

  assign samp_o = samp_q;
endmodule

// File: rtl/mbox_cmd_if.sv
`timescale 1ns/1ps
module mbox_cmd_if
  import mbox_pkg::*;
#(
  parameter int NUM_PWM    = 2,
  parameter int LATENCY    = 3,
  parameter int SAMPLE_DIV = 12500
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic [7:0] din_i,
  output logic [7:0] dout_o
);
  logic             trig;
  cmd_t             trig_cmd;
  logic [7:0]       echo_w, samp_w;
  logic [PAR_W-1:0] fb_w;

  mbox_host_port u_port (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .fb_i       (fb_w),
    .echo_i     (echo_w),
    .samp_i     (samp_w),
    .trig_o     (trig),
    .trig_cmd_o (trig_cmd)
  );

  mbox_exec #(.NUM_PWM(NUM_PWM), .LATENCY(LATENCY)) u_exec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (trig),
    .cmd_i  (trig_cmd),
    .echo_o (echo_w),
    .fb_o   (fb_w),
    .dout_o (dout_o)
  );

  mbox_din_sampler #(.W(BYTE_W), .DIV(SAMPLE_DIV)) u_smp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .din_i  (din_i),
    .samp_o (samp_w)
  );
endmodule

// File: rtl/mbox_cmd_if_chk.sv
`timescale 1ns/1ps
module mbox_cmd_if_chk #(
  parameter int LATENCY    = 3,
  parameter int SAMPLE_DIV = 12500
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_i,
  input logic [2:0] addr_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic [7:0] dout_o,
  input logic [7:0] echo_i,
  input logic [7:0] samp_i
);
  localparam int CW = $clog2(LATENCY + 1);
  localparam int PW = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;

  logic [CW-1:0] pend_q;
  logic [7:0]    cap_q;
  logic [PW-1:0] div_q;
  logic          trig, due, tick;

  assign trig = wr_i && (addr_i == 3'd2);
  assign due  = (pend_q == CW'(1)) && !trig;
  assign tick = (div_q == PW'(SAMPLE_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      cap_q  <= '0;
      div_q  <= '0;
    end else begin
      div_q <= tick ? '0 : div_q + PW'(1);
      if (trig) begin
        pend_q <= CW'(LATENCY);
        cap_q  <= wdata_i;
      end else if (pend_q != '0) begin
        pend_q <= pend_q - CW'(1);
      end
    end
  end

  assert_rsv_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 3'd3) |-> (rdata_o == 8'h00));

  assert_echo_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !due |=> $stable(echo_i));

  assert_echo_code_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    due |=> (echo_i == $past(cap_q)));

  assert_dout_only_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(due && cap_q == 8'h01) |=> $stable(dout_o));

  assert_din_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(samp_i));
endmodule

bind mbox_cmd_if mbox_cmd_if_chk #(.LATENCY(LATENCY), .SAMPLE_DIV(SAMPLE_DIV)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_i    (wr_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .dout_o  (dout_o),
  .echo_i  (echo_w),
  .samp_i  (samp_w)
);

// File: tb/sim_mbox_cmd_if.sv
`timescale 1ns/1ps
module sim_mbox_cmd_if;
  localparam int LAT = 3;
  localparam int DIV = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] din = 8'h00;
  logic [7:0] rdata, dout;

  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mbox_cmd_if #(.NUM_PWM(2), .LATENCY(LAT), .SAMPLE_DIV(DIV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .din_i(din), .dout_o(dout)
  );

  // behavioural reference model
  logic [7:0]  m_lo, m_hi, m_cmd, m_echo, m_dout, m_samp, m_pc;
  logic [15:0] m_fb, m_pp;
  int          m_pend, m_cyc;
  logic [15:0] m_cfg [int];
  logic [7:0]  m_hist [$];

  function automatic bit is_setting(input logic [7:0] c);
    return (c == 8'h01) || (c >= 8'h10 && c <= 8'h15) || (c == 8'h1F);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lo = 0; m_hi = 0; m_cmd = 0; m_echo = 0; m_dout = 0; m_samp = 0;
      m_pc = 0; m_fb = 0; m_pp = 0; m_pend = 0; m_cyc = 0;
      m_cfg.delete();
      m_hist = '{8'h00, 8'h00};
    end else begin
      bit trig;
      trig = wr && addr == 3'd2;
      m_hist.push_back(din);
      m_cyc++;
      if (m_cyc % DIV == 0) m_samp = m_hist[0];
      m_hist.pop_front();
      if (m_pend == 1 && !trig) begin
        m_echo = m_pc;
        m_fb = 16'h0000;
        if (m_pc == 8'h01) m_dout = m_pp[7:0];
        if (m_pc == 8'h02) m_fb = {8'h00, m_dout};
        if (m_pc == 8'h07 && m_cfg.exists(int'(m_pp[7:0]))) m_fb = m_cfg[int'(m_pp[7:0])];
        if (is_setting(m_pc))
          m_cfg[int'(m_pc)] = (m_pc == 8'h01) ? {8'h00, m_pp[7:0]} :
                              (m_pc == 8'h1F) ? (m_pp & 16'h0003) : m_pp;
      end
      if (trig) begin
        m_pend = LAT; m_pc = wdata; m_pp = {m_hi, m_lo};
      end else if (m_pend > 0) m_pend--;
      if (wr && addr == 3'd0) m_lo = wdata;
      if (wr && addr == 3'd1) m_hi = wdata;
      if (wr && addr == 3'd2) m_cmd = wdata;
    end
  end

  function automatic logic [7:0] m_byte(input logic [2:0] a);
    case (a)
      3'd0: return m_lo;
      3'd1: return m_hi;
      3'd2: return m_cmd;
      3'd4: return m_fb[7:0];
      3'd5: return m_fb[15:8];
      3'd6: return m_echo;
      3'd7: return m_samp;
      default: return 8'h00;
    endcase
  endfunction

  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      nvec++;
      if (rdata !== m_byte(addr)) begin
        nbad++;
        $display("FAIL %s model addr %0d: got %02h exp %02h",
                 (addr == 3'd7) ? "R10" : (addr >= 3'd4) ? "R3" : "R2",
                 addr, rdata, m_byte(addr));
      end
      nvec++;
      if (dout !== m_dout) begin
        nbad++;
        $display("FAIL R5 model dout: got %02h exp %02h", dout, m_dout);
      end
    end
  end

  task automatic chk_rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = a;
    #2;
    nvec++;
    if (rdata !== exp) begin
      nbad++;
      $display("FAIL %s read addr %0d: got %02h exp %02h", tag, a, rdata, exp);
    end
  endtask

  task automatic chk_out(input logic [7:0] exp, input string tag);
    nvec++;
    if (dout !== exp) begin
      nbad++;
      $display("FAIL %s dout: got %02h exp %02h", tag, dout, exp);
    end
  endtask

  task automatic wr_byte(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic run(input logic [7:0] c, input logic [15:0] p);
    wr_byte(3'd0, p[7:0]);
    wr_byte(3'd1, p[15:8]);
    wr_byte(3'd2, c);
    repeat (LAT) @(posedge clk);
  endtask

  task automatic chk_fb(input logic [15:0] exp, input string tag);
    chk_rd(3'd4, exp[7:0], tag);
    chk_rd(3'd5, exp[15:8], tag);
  endtask

  task automatic cfg_rd(input logic [7:0] code, input logic [15:0] exp, input string tag);
    run(8'h07, {8'h00, code});
    chk_rd(3'd6, 8'h07, tag);
    chk_fb(exp, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 8; a++) chk_rd(3'(a), 8'h00, "R1");
    chk_out(8'h00, "R1");

    // R2 map and write protection
    wr_byte(3'd0, 8'hA5);
    wr_byte(3'd1, 8'h3C);
    chk_rd(3'd0, 8'hA5, "R2");
    chk_rd(3'd1, 8'h3C, "R2");
    wr_byte(3'd3, 8'hFF);
    chk_rd(3'd3, 8'h00, "R2");
    wr_byte(3'd6, 8'h55);
    chk_rd(3'd6, 8'h00, "R2");
    wr_byte(3'd4, 8'h77);
    chk_rd(3'd4, 8'h00, "R2");

    // R3 completion timing, R5 output load
    wr_byte(3'd2, 8'h01);
    repeat (LAT - 1) @(posedge clk);
    chk_rd(3'd6, 8'h00, "R3");
    chk_out(8'h00, "R3");
    @(posedge clk);
    chk_rd(3'd6, 8'h01, "R3");
    chk_out(8'hA5, "R5");
    chk_fb(16'h0000, "R5");
    chk_rd(3'd2, 8'h01, "R2");

    run(8'h02, 16'h0000);
    chk_rd(3'd6, 8'h02, "R5");
    chk_fb(16'h00A5, "R5");

    // R4 clear then reissue
    run(8'h00, 16'h0000);
    chk_rd(3'd6, 8'h00, "R4");
    chk_fb(16'h0000, "R4");
    run(8'h02, 16'h0000);
    chk_rd(3'd6, 8'h02, "R4");

    // R6 settings, R7 readback
    run(8'h10, 16'h1234);
    chk_fb(16'h0000, "R6");
    run(8'h13, 16'hBEEF);
    run(8'h15, 16'h0042);
    run(8'h14, 16'h0101);
    run(8'h1F, 16'hFFFF);
    cfg_rd(8'h10, 16'h1234, "R6");
    cfg_rd(8'h13, 16'hBEEF, "R6");
    cfg_rd(8'h15, 16'h0042, "R6");
    cfg_rd(8'h14, 16'h0101, "R6");
    cfg_rd(8'h1F, 16'h0003, "R6");
    cfg_rd(8'h11, 16'h0000, "R7");
    cfg_rd(8'h12, 16'h0000, "R7");
    cfg_rd(8'h01, 16'h00A5, "R7");
    cfg_rd(8'h02, 16'h0000, "R7");

    // R8 unknown code
    run(8'h5A, 16'h7777);
    chk_rd(3'd6, 8'h5A, "R8");
    chk_fb(16'h0000, "R8");
    cfg_rd(8'h1F, 16'h0003, "R8");
    chk_out(8'hA5, "R8");

    // R9 replacement of a pending command
    wr_byte(3'd0, 8'h0F);
    wr_byte(3'd1, 8'h00);
    wr_byte(3'd2, 8'h01);
    wr_byte(3'd2, 8'h02);
    repeat (LAT) @(posedge clk);
    chk_rd(3'd6, 8'h02, "R9");
    chk_fb(16'h00A5, "R9");
    repeat (LAT) @(posedge clk);
    chk_out(8'hA5, "R9");

    // R11 parameter captured at trigger
    wr_byte(3'd0, 8'h3C);
    wr_byte(3'd2, 8'h01);
    wr_byte(3'd0, 8'hC3);
    repeat (LAT) @(posedge clk);
    chk_out(8'h3C, "R11");
    chk_rd(3'd0, 8'hC3, "R11");

    // R10 input sampling
    @(negedge clk);
    addr = 3'd7;
    din = 8'h81;
    repeat (3 * DIV) @(posedge clk);
    chk_rd(3'd7, 8'h81, "R10");
    din = 8'h18;
    repeat (3 * DIV) @(posedge clk);
    chk_rd(3'd7, 8'h18, "R10");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nbad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule